// File: doc/BRIEF.md
# Configurable Output Logic Cell Bank

This block holds the output cells that sit between the fixed OR array of a sum-of-products programmable logic device and its I/O pins. Each cell takes its OR-sum term and either passes it straight through or holds it in a D flip-flop clocked on the rising edge. It can invert the chosen value before it reaches the pin driver. The mode also decides what goes back into the product-term array: in registered mode the array sees the stored bit, and in combinatorial mode it sees the level actually present on the pin. When the cell's output enable is low, the pin can therefore serve as an input.

Every cell shares the clock, a global asynchronous clear, a global synchronous preset and a test preload strobe. Each cell has its own two configuration bits, sum term, output-enable term and pin input level. The asynchronous clear doubles as the power-up initialisation: holding it from power-on leaves every register at 0. All signals are plain level controls. No data stream passes through the block, so it has no valid/ready handshake and never applies back-pressure.

Top module: `pal_olmc_bank`

## Requirements
- R1: The configuration bits select the output polarity. `cfg_pol` = 1 drives the selected value unchanged onto `pin_out`, and `cfg_pol` = 0 drives its complement. The encoding {`cfg_mode`,`cfg_pol`} is 00 registered/active-low, 01 registered/active-high, 10 combinatorial/active-low, 11 combinatorial/active-high.
- R2: With no clear, preload or preset, each cell's register captures `sum_term` on a rising `clk` edge. In registered mode (`cfg_mode` = 0), the captured value appears on `pin_out` and `fb` after that edge.
- R3: In registered mode, `fb` equals the register's stored value, whatever `pin_in` is.
- R4: In combinatorial mode (`cfg_mode` = 1), `pin_out` follows `sum_term` with no clock edge, through the polarity selection.
- R5: In combinatorial mode, `fb` equals `pin_in`, including while `oe_term` is low.
- R6: Asserting `rst_async` clears every register at once, with no clock edge needed. Holding it from power-on gives a 0 initial state.
- R7: If `preset_term` is high at a rising edge, every register is set to 1 at that edge. Raising it between edges changes nothing until the next edge.
- R8: `rst_async` overrides both preset and preload.
- R9: If `preload_en` is high at a rising edge, each register loads its bit of `preload_val`. Preload takes priority over both preset and `sum_term`.
- R10: `pin_oe` equals `oe_term` for each cell in every mode.
- R11: The register keeps capturing `sum_term` while its cell is in combinatorial mode. After a switch to registered mode, the last value captured shows on `fb` with no further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_async | input | 1 | Global asynchronous clear, active high; also used as power-up init |
| preset_term | input | 1 | Global synchronous preset, active high |
| preload_en | input | 1 | Test preload strobe, active high |
| preload_val | input | N_CELLS | Per-cell preload value |
| cfg_mode | input | N_CELLS | Per-cell mode bit: 0 registered, 1 combinatorial |
| cfg_pol | input | N_CELLS | Per-cell polarity bit: 0 active low, 1 active high |
| sum_term | input | N_CELLS | Per-cell OR-sum term from the array |
| oe_term | input | N_CELLS | Per-cell output-enable term |
| pin_in | input | N_CELLS | Level sensed on each pin |
| pin_out | output | N_CELLS | Value for each pin driver |
| pin_oe | output | N_CELLS | Enable for each pin driver |
| fb | output | N_CELLS | Feedback to the product-term array |

## Verification
The main function is swept over every sum-term pattern against every pin-input pattern. This is repeated under four rotations of the configuration, so that all four modes are live at once on different cells. Sum and pin patterns that differ separate feedback taken from the pin from feedback taken from the register. Each sum pattern is registered and then compared on the next vector, which separates a cell that captured on the edge from one that passes the term straight through. Mixed polarities across the cells show up a polarity bit applied to the wrong cell or in the wrong sense. Directed sequences cover the control terms: clear raised between edges, preset raised between edges, clear, preset and preload all raised together, preload against preset, and a switch from combinatorial to registered mode.

// File: rtl/pal_olmc_pkg.sv
`timescale 1ns/1ps
package pal_olmc_pkg;

  // {mode, polarity}: mode 1 bypasses the register, polarity 1 is active high
  typedef enum logic [1:0] {
    OLMC_REG_LOW  = 2'b00,
    OLMC_REG_HIGH = 2'b01,
    OLMC_CMB_LOW  = 2'b10,
    OLMC_CMB_HIGH = 2'b11
  } olmc_cfg_e;

  function automatic logic cfg_is_comb(olmc_cfg_e c);
    return c[1];
  endfunction

  function automatic logic cfg_is_high(olmc_cfg_e c);
    return c[0];
  endfunction

endpackage

// File: rtl/pal_olmc_reg.sv
`timescale 1ns/1ps
module pal_olmc_reg (
  input  logic clk,
  input  logic rst_async,
  input  logic preset_term,
  input  logic preload_en,
  input  logic preload_bit,
  input  logic d_i,
  output logic q_o
);

  // clear is asynchronous and beats everything; preload beats preset
  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async)        q_o <= 1'b0;
    else if (preload_en)  q_o <= preload_bit;
    else if (preset_term) q_o <= 1'b1;
    else                  q_o <= d_i;
  end

endmodule

// File: rtl/pal_olmc_route.sv
`timescale 1ns/1ps
module pal_olmc_route
  import pal_olmc_pkg::*;
(
  input  olmc_cfg_e cfg,
  input  logic      sum_i,
  input  logic      q_i,
  input  logic      pin_i,
  input  logic      oe_i,
  output logic      pin_o,
  output logic      pin_oe_o,
  output logic      fb_o
);

  logic sel;

  always_comb begin
    sel      = cfg_is_comb(cfg) ? sum_i : q_i;
    // polarity is applied after the bypass mux, just ahead of the driver
    pin_o    = cfg_is_high(cfg) ? sel : ~sel;
    pin_oe_o = oe_i;
    fb_o     = cfg_is_comb(cfg) ? pin_i : q_i;
  end

endmodule

// File: rtl/pal_olmc_cell.sv
`timescale 1ns/1ps
module pal_olmc_cell
  import pal_olmc_pkg::*;
(
  input  logic clk,
  input  logic rst_async,
  input  logic preset_term,
  input  logic preload_en,
  input  logic preload_bit,
  input  logic mode_bit,
  input  logic pol_bit,
  input  logic sum_i,
  input  logic oe_i,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic fb_o
);

  olmc_cfg_e cfg;
  logic      q;

  assign cfg = olmc_cfg_e'({mode_bit, pol_bit});

  pal_olmc_reg u_reg (
    .clk         (clk),
    .rst_async   (rst_async),
    .preset_term (preset_term),
    .preload_en  (preload_en),
    .preload_bit (preload_bit),
    .d_i         (sum_i),
    .q_o         (q)
  );

  pal_olmc_route u_route (
    .cfg      (cfg),
    .sum_i    (sum_i),
    .q_i      (q),
    .pin_i    (pin_i),
    .oe_i     (oe_i),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o),
    .fb_o     (fb_o)
  );

endmodule

// File: rtl/pal_olmc_bank.sv
`timescale 1ns/1ps
module pal_olmc_bank #(
  parameter int N_CELLS = 4
) (
  input  logic               clk,
  input  logic               rst_async,
  input  logic               preset_term,
  input  logic               preload_en,
  input  logic [N_CELLS-1:0] preload_val,
  input  logic [N_CELLS-1:0] cfg_mode,
  input  logic [N_CELLS-1:0] cfg_pol,
  input  logic [N_CELLS-1:0] sum_term,
  input  logic [N_CELLS-1:0] oe_term,
  input  logic [N_CELLS-1:0] pin_in,
  output logic [N_CELLS-1:0] pin_out,
  output logic [N_CELLS-1:0] pin_oe,
  output logic [N_CELLS-1:0] fb
);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    pal_olmc_cell u_cell (
      .clk         (clk),
      .rst_async   (rst_async),
      .preset_term (preset_term),
      .preload_en  (preload_en),
      .preload_bit (preload_val[i]),
      .mode_bit    (cfg_mode[i]),
      .pol_bit     (cfg_pol[i]),
      .sum_i       (sum_term[i]),
      .oe_i        (oe_term[i]),
      .pin_i       (pin_in[i]),
      .pin_o       (pin_out[i]),
      .pin_oe_o    (pin_oe[i]),
      .fb_o        (fb[i])
    );
  end

endmodule

// File: rtl/pal_olmc_bank_chk.sv
`timescale 1ns/1ps
module pal_olmc_bank_chk #(
  parameter int N_CELLS = 4
) (
  input logic               clk,
  input logic               rst_async,
  input logic               preset_term,
  input logic               preload_en,
  input logic [N_CELLS-1:0] preload_val,
  input logic [N_CELLS-1:0] cfg_mode,
  input logic [N_CELLS-1:0] cfg_pol,
  input logic [N_CELLS-1:0] sum_term,
  input logic [N_CELLS-1:0] oe_term,
  input logic [N_CELLS-1:0] pin_in,
  input logic [N_CELLS-1:0] pin_out,
  input logic [N_CELLS-1:0] pin_oe,
  input logic [N_CELLS-1:0] fb
);

  for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
    AST_REG_POLARITY: assert property (@(posedge clk) disable iff (rst_async)
      !cfg_mode[i] |-> (pin_out[i] == (cfg_pol[i] ? fb[i] : !fb[i]))); // R1

    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst_async)
      ($past(!rst_async && !preload_en && !preset_term) && !cfg_mode[i])
        |-> (fb[i] == $past(sum_term[i]))); // R2

    AST_CMB_FEEDBACK: assert property (@(posedge clk) disable iff (rst_async)
      cfg_mode[i] |-> (fb[i] == pin_in[i])); // R5

    AST_CLEAR_HOLDS: assert property (@(posedge clk)
      (rst_async && !cfg_mode[i]) |-> !fb[i]); // R6

    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (rst_async)
      ($past(!rst_async && preset_term && !preload_en) && !cfg_mode[i])
        |-> fb[i]); // R7

    AST_PRELOAD_LOADS: assert property (@(posedge clk) disable iff (rst_async)
      ($past(!rst_async && preload_en) && !cfg_mode[i])
        |-> (fb[i] == $past(preload_val[i]))); // R9

    AST_OE_PASS: assert property (@(posedge clk) disable iff (rst_async)
      $past(!rst_async) |-> (pin_oe[i] == oe_term[i])); // R10
  end

endmodule

bind pal_olmc_bank pal_olmc_bank_chk #(.N_CELLS(N_CELLS)) u_chk (.*);

// File: tb/pal_olmc_bank_tb_top.sv
`timescale 1ns/1ps
module pal_olmc_bank_tb_top;

  localparam int N = 4;
  localparam int NPAT = 1 << N;

  logic         clk = 1'b0;
  logic         rst_async = 1'b1;
  logic         preset_term = 1'b0;
  logic         preload_en = 1'b0;
  logic [N-1:0] preload_val = '0;
  logic [N-1:0] cfg_mode = '0;
  logic [N-1:0] cfg_pol = '0;
  logic [N-1:0] sum_term = '0;
  logic [N-1:0] oe_term = '0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, fb;

  logic [N-1:0] m_q = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pal_olmc_bank #(.N_CELLS(N)) dut_i (
    .clk(clk), .rst_async(rst_async), .preset_term(preset_term),
    .preload_en(preload_en), .preload_val(preload_val),
    .cfg_mode(cfg_mode), .cfg_pol(cfg_pol), .sum_term(sum_term),
    .oe_term(oe_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one rising edge; model follows the requirement priorities, then settle
  task automatic tick();
    @(posedge clk);
    if (rst_async)        m_q = '0;
    else if (preload_en)  m_q = preload_val;
    else if (preset_term) m_q = '1;
    else                  m_q = sum_term;
    #1;
  endtask

  task automatic check_all(input string tag);
    logic [N-1:0] sel, exp_out, exp_fb;
    sel     = (cfg_mode & sum_term) | (~cfg_mode & m_q);
    exp_out = (cfg_pol & sel) | (~cfg_pol & ~sel);
    exp_fb  = (cfg_mode & pin_in) | (~cfg_mode & m_q);
    chk({tag, " R1/R4 pin_out"}, pin_out, exp_out);
    chk({tag, " R3/R5 fb"}, fb, exp_fb);
    chk({tag, " R10 pin_oe"}, pin_oe, oe_term);
  endtask

  task automatic set_cfg(input int rot);
    for (int i = 0; i < N; i++) begin
      cfg_mode[i] = ((rot + i) % 4) >= 2;
      cfg_pol[i]  = ((rot + i) % 2) == 1;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // power-up: clear held from time zero, registers must read 0 (R6)
    tick(); tick();
    chk("R6 power-up fb", fb, '0);
    chk("R1 power-up active-low pin_out", pin_out, '1);
    rst_async = 1'b0;
    tick();

    // exhaustive sweep: 4 config rotations x sum patterns x pin patterns (R2)
    for (int rot = 0; rot < 4; rot++) begin
      set_cfg(rot);
      for (int s = 0; s < NPAT; s++) begin
        for (int p = 0; p < NPAT; p++) begin
          sum_term = N'(s);
          pin_in   = N'(p);
          oe_term  = N'(s ^ p);
          #1;
          check_all("R4 comb pre-edge");
          tick();
          check_all("R2 post-edge");
        end
      end
    end

    // all registered, active high, for direct register views
    cfg_mode = '0; cfg_pol = '1; oe_term = '0;
    sum_term = 4'b0110; tick();
    chk("R2 captured", fb, 4'b0110);

    // async clear between edges (R6)
    #0.5 rst_async = 1'b1; #0.5;
    m_q = '0;
    chk("R6 clear without edge", fb, '0);
    tick();
    rst_async = 1'b0;
    tick();
    chk("R2 after clear", fb, 4'b0110);

    // preset raised between edges: no change until the edge (R7)
    sum_term = 4'b0000; tick();
    preset_term = 1'b1; #0.5;
    chk("R7 preset waits for edge", fb, 4'b0000);
    tick();
    chk("R7 preset sets", fb, 4'b1111);
    preset_term = 1'b0;

    // preload beats preset and sum (R9)
    preload_en = 1'b1; preload_val = 4'b1010; preset_term = 1'b1; sum_term = 4'b0101;
    tick();
    chk("R9 preload over preset", fb, 4'b1010);
    preset_term = 1'b0;
    preload_val = 4'b0011; tick();
    chk("R9 preload over sum", fb, 4'b0011);

    // clear beats preload and preset (R8)
    preset_term = 1'b1; rst_async = 1'b1; #0.5; m_q = '0;
    tick();
    chk("R8 clear over preload/preset", fb, '0);
    rst_async = 1'b0; preload_en = 1'b0; preset_term = 1'b0;

    // register keeps clocking in combinatorial mode (R11)
    cfg_mode = '1; sum_term = 4'b1001; pin_in = 4'b0110; oe_term = '0;
    tick();
    chk("R5 comb fb from pin with oe low", fb, 4'b0110);
    cfg_mode = '0; #1;
    chk("R11 hidden capture visible", fb, 4'b1001);
    cfg_pol = 4'b0101; #1;
    check_all("R11 mixed polarity");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule